// File: doc/BRIEF.md
# Exception Arbiter and Entry Sequencer

This block chooses which pending exception a small processor core takes next and decides when to take it. It also runs the entry and return sequences around the handler. Three sources sit at fixed levels and ignore any disable: a reset request, a non-maskable request and a hard fault. The other sources each have a programmable priority and an enable. These are the supervisor call, the pendable service request, the system tick and the peripheral interrupt lines. A request pulse marks its source pending. The pending source with the highest level preempts the running code only when it outranks the current execution level.

On a normal entry the block asks an external stacking engine for a context push and waits for the engine's done strobe. It then offers the handler's vector address to the core. If a higher-level exception becomes pending while the push burst is still running, the already-saved context is reused and the offered vector switches to the new winner (late arrival). When the core signals exception return, two outcomes are possible. If an eligible exception outranks the level being returned to, the block vectors to it straight away with no pop and no push (tail chain). Otherwise it requests a context pop. A small stack of active levels, up to four deep, tracks the execution level across nesting.

The stacking request (`stk_req_*`) and the vector offer (`vec_*`) are valid/ready channels. Once raised, valid and its payload stay unchanged until the cycle in which ready is high, and the transfer happens on that edge. The receiver may hold ready low for any number of cycles. The engine's `stk_done` is a one-cycle strobe that ends a burst. Request inputs, configuration and `exc_return` are plain level or strobe pins.

Top module: `excp_sequencer`

## Requirements
- R1: After reset no source is pending, `stk_req_valid` and `vec_valid` are low and `exec_lvl` reads 7, the thread level.
- R2: Levels are encoded so that lower means more urgent. Reset is level 0, the non-maskable request is 1 and hard fault is 2. A configurable source with priority p is at level 3+p. Among eligible pending sources the lowest level wins, and on a tie the lower exception number wins.
- R3: A configurable source whose enable bit is 0 is never taken, but it stays pending and is taken once enabled. The three fixed sources have no enable and are always eligible.
- R4: Exception numbers are 1 for reset, 2 for non-maskable, 3 for hard fault, 11 for supervisor call, 14 for pendable service, 15 for system tick and 16+n for IRQ n. `vec_addr` equals `vec_base` + 4 × `vec_num`.
- R5: A pending source preempts only when its level is strictly lower than `exec_lvl`; equal or higher levels wait. After a vector is accepted, `exec_lvl` equals the taken source's level.
- R6: A normal entry issues exactly one push request (`stk_req_pop`=0), and the vector is offered only after `stk_done`. `stk_req_psp` equals `thread_psp` when entering from thread level and 0 when entering from a handler.
- R7: If a higher-level source becomes pending after the push has been requested and before `stk_done`, the offered vector is that source, with no second push. The displaced source stays pending.
- R8: On `exc_return`, if an eligible pending source outranks the level being returned to, its vector is offered next with neither a pop nor a push.
- R9: On `exc_return` with no such source, one pop request is issued (`stk_req_pop`=1), and `exec_lvl` becomes the level that was preempted. A pop back to thread level carries the `thread_psp` value saved at the first entry.
- R10: At most 4 exceptions can be active at once. While 4 are active no preemption happens, even by a fixed-level source.
- R11: `stk_req_valid` and `vec_valid` hold, with stable payload, until their ready is high.
- R12: `exc_return` at thread level is ignored: no pop, and `exec_lvl` stays 7.
- R13: Accepting a vector clears that source's pending state, so each request pulse yields exactly one handler entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_base | input | 32 | Base address of the vector table |
| thread_psp | input | 1 | 1 when thread code runs on the process stack |
| rst_exc_req | input | 1 | Reset exception request pulse |
| nmi_req | input | 1 | Non-maskable request pulse |
| hardfault_req | input | 1 | Hard fault request pulse |
| svc_req | input | 1 | Supervisor call request pulse |
| pendsv_req | input | 1 | Pendable service request pulse |
| systick_req | input | 1 | System tick request pulse |
| irq_req | input | NUM_IRQ | Peripheral request pulses, bit n is IRQ n |
| cfg_prio | input | (NUM_IRQ+3)×PRIO_W | Priority per configurable source. Slot 0 supervisor call, 1 pendable service, 2 system tick, 3+n IRQ n |
| cfg_en | input | NUM_IRQ+3 | Enable per configurable source, same slot order as `cfg_prio` |
| exc_return | input | 1 | Handler-return strobe from the core |
| stk_req_valid | output | 1 | Stacking request valid |
| stk_req_ready | input | 1 | Stacking engine accepts the request |
| stk_req_pop | output | 1 | 0 = push context, 1 = pop context |
| stk_req_psp | output | 1 | 1 = use the process stack, 0 = main stack |
| stk_done | input | 1 | One-cycle end-of-burst strobe |
| vec_valid | output | 1 | Handler vector offered |
| vec_ready | input | 1 | Core accepts the vector |
| vec_num | output | $clog2(16+NUM_IRQ) | Exception number being entered |
| vec_addr | output | 32 | Vector table slot address |
| exec_lvl | output | $clog2(4+2^PRIO_W) | Current execution level, 7 = thread |

## Verification
Two events can coincide. A return can arrive in the same cycle as a pending exception, which must then be tail-chained rather than popped. A higher-level request can land inside a push burst, which must redirect the vector without a second push. The bench provokes the first in every pair of a sweep over all source pairs under several priority maps: both sources are raised together, the winner's handler returns, and the other source is pending at that return. The bench judges this by counting push and pop handshakes at the modelled stacking engine and by comparing vector numbers and addresses with values computed from the level rules. The second case is provoked by raising a more urgent line after the push handshake has been seen. The bench judges it by checking the offered vector and confirming that the push count did not grow.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int NFIX = 3;  // reset, non-maskable, hard fault
  localparam int NSYS = 3;  // supervisor call, pendable service, system tick

  typedef enum logic [2:0] {
    S_RUN, S_PUSH_REQ, S_PUSH_WAIT, S_VEC, S_POP_REQ, S_POP_WAIT
  } seq_state_e;

  // Exception number of source index (index 0 is the reset request)
  function automatic int src_excnum(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 11;
      4: return 14;
      5: return 15;
      default: return 16 + idx - (NFIX + NSYS);
    endcase
  endfunction
endpackage

// File: rtl/excp_pend_bank.sv
module excp_pend_bank #(
  parameter int NSRC  = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_vec,
  input  logic             clr,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NSRC-1:0]  pend
);
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                  pend[g] <= 1'b0;
      else if (set_vec[g])                         pend[g] <= 1'b1;
      else if (clr && clr_idx == IDX_W'(g))        pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/excp_prio_pick.sv
module excp_prio_pick #(
  parameter int NSRC  = 10,
  parameter int LVL_W = 3,
  parameter int IDX_W = 4
) (
  input  logic [NSRC-1:0]       cand,
  input  logic [NSRC*LVL_W-1:0] lvl_flat,
  output logic                  pick_valid,
  output logic [IDX_W-1:0]      pick_idx,
  output logic [LVL_W-1:0]      pick_lvl
);
  // Strict compare in ascending index order: ties keep the lower number
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    pick_lvl   = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!pick_valid || lvl_flat[i*LVL_W +: LVL_W] < pick_lvl)) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(i);
        pick_lvl   = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/excp_active_stack.sv
module excp_active_stack #(
  parameter int DEPTH      = 4,
  parameter int LVL_W      = 3,
  parameter int THREAD_LVL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] top_lvl,
  output logic [LVL_W-1:0] below_lvl,
  output logic             full,
  output logic             empty,
  output logic             depth_one
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (push) cnt <= cnt + 1'b1;
    else if (pop)  cnt <= cnt - 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && cnt == CNT_W'(e)) mem[e] <= push_lvl;
    end
  end

  always_comb begin
    top_lvl   = LVL_W'(THREAD_LVL);
    below_lvl = LVL_W'(THREAD_LVL);
    for (int e = 0; e < DEPTH; e++) begin
      if (cnt == CNT_W'(e + 1)) top_lvl   = mem[e];
      if (cnt == CNT_W'(e + 2)) below_lvl = mem[e];
    end
  end

  assign full      = (cnt == CNT_W'(DEPTH));
  assign empty     = (cnt == '0);
  assign depth_one = (cnt == CNT_W'(1));
endmodule

// File: rtl/excp_sequencer.sv
module excp_sequencer
  import excp_pkg::*;
#(
  parameter int NUM_IRQ    = 4,
  parameter int PRIO_W     = 2,
  parameter int NEST_DEPTH = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [31:0]                              vec_base,
  input  logic                                     thread_psp,
  input  logic                                     rst_exc_req,
  input  logic                                     nmi_req,
  input  logic                                     hardfault_req,
  input  logic                                     svc_req,
  input  logic                                     pendsv_req,
  input  logic                                     systick_req,
  input  logic [NUM_IRQ-1:0]                       irq_req,
  input  logic [(NUM_IRQ+NSYS)*PRIO_W-1:0]         cfg_prio,
  input  logic [NUM_IRQ+NSYS-1:0]                  cfg_en,
  input  logic                                     exc_return,
  output logic                                     stk_req_valid,
  input  logic                                     stk_req_ready,
  output logic                                     stk_req_pop,
  output logic                                     stk_req_psp,
  input  logic                                     stk_done,
  output logic                                     vec_valid,
  input  logic                                     vec_ready,
  output logic [$clog2(16+NUM_IRQ)-1:0]            vec_num,
  output logic [31:0]                              vec_addr,
  output logic [$clog2(NFIX+(1<<PRIO_W)+1)-1:0]    exec_lvl
);
  localparam int NCFG       = NSYS + NUM_IRQ;
  localparam int NSRC       = NFIX + NCFG;
  localparam int THREAD_LVL = NFIX + (1 << PRIO_W);
  localparam int LVL_W      = $clog2(THREAD_LVL + 1);
  localparam int NUM_W      = $clog2(16 + NUM_IRQ);
  localparam int IDX_W      = $clog2(NSRC);

  // Source tables: level, eligibility, exception number
  logic [NSRC-1:0]       req_vec, src_en, pend;
  logic [NSRC*LVL_W-1:0] lvl_flat;
  logic [NUM_W-1:0]      num_tab [NSRC];

  assign req_vec = {irq_req, systick_req, pendsv_req, svc_req,
                    hardfault_req, nmi_req, rst_exc_req};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign num_tab[g] = NUM_W'(src_excnum(g));
    if (g < NFIX) begin : g_fixed
      assign lvl_flat[g*LVL_W +: LVL_W] = LVL_W'(g);
      assign src_en[g] = 1'b1;
    end else begin : g_cfg
      assign lvl_flat[g*LVL_W +: LVL_W] =
        LVL_W'(NFIX) + LVL_W'(cfg_prio[(g-NFIX)*PRIO_W +: PRIO_W]);
      assign src_en[g] = cfg_en[g-NFIX];
    end
  end

  seq_state_e       state;
  logic [IDX_W-1:0] sel_idx, pick_idx;
  logic [LVL_W-1:0] sel_lvl, pick_lvl, top_lvl, below_lvl;
  logic             pick_valid, full, empty, depth_one;
  logic             psp_q, thr_psp_q;
  logic             take_vec, ret_pop, late_hit;

  assign take_vec = (state == S_VEC) && vec_ready;
  assign ret_pop  = (state == S_RUN) && exc_return && !empty;
  assign late_hit = pick_valid && (pick_lvl < sel_lvl);

  excp_pend_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(req_vec),
    .clr(take_vec), .clr_idx(sel_idx), .pend(pend)
  );

  excp_prio_pick #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .cand(pend & src_en), .lvl_flat(lvl_flat),
    .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_lvl(pick_lvl)
  );

  excp_active_stack #(.DEPTH(NEST_DEPTH), .LVL_W(LVL_W), .THREAD_LVL(THREAD_LVL)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take_vec), .push_lvl(sel_lvl), .pop(ret_pop),
    .top_lvl(top_lvl), .below_lvl(below_lvl), .full(full), .empty(empty),
    .depth_one(depth_one)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_RUN;
      sel_idx   <= '0;
      sel_lvl   <= LVL_W'(THREAD_LVL);
      psp_q     <= 1'b0;
      thr_psp_q <= 1'b0;
    end else begin
      case (state)
        S_RUN: begin
          if (ret_pop) begin
            if (pick_valid && pick_lvl < below_lvl) begin
              sel_idx <= pick_idx;          // tail chain: no pop, no push
              sel_lvl <= pick_lvl;
              state   <= S_VEC;
            end else begin
              psp_q <= depth_one & thr_psp_q;
              state <= S_POP_REQ;
            end
          end else if (pick_valid && pick_lvl < top_lvl && !full) begin
            sel_idx <= pick_idx;
            sel_lvl <= pick_lvl;
            psp_q   <= empty & thread_psp;
            if (empty) thr_psp_q <= thread_psp;
            state   <= S_PUSH_REQ;
          end
        end
        S_PUSH_REQ: begin
          if (late_hit) begin
            sel_idx <= pick_idx;
            sel_lvl <= pick_lvl;
          end
          if (stk_req_ready) state <= S_PUSH_WAIT;
        end
        S_PUSH_WAIT: begin
          if (stk_done) state <= S_VEC;
          else if (late_hit) begin
            sel_idx <= pick_idx;
            sel_lvl <= pick_lvl;
          end
        end
        S_VEC:      if (vec_ready)     state <= S_RUN;
        S_POP_REQ:  if (stk_req_ready) state <= S_POP_WAIT;
        S_POP_WAIT: if (stk_done)      state <= S_RUN;
        default:                       state <= S_RUN;
      endcase
    end
  end

  assign stk_req_valid = (state == S_PUSH_REQ) || (state == S_POP_REQ);
  assign stk_req_pop   = (state == S_POP_REQ);
  assign stk_req_psp   = psp_q;
  assign vec_valid     = (state == S_VEC);
  assign vec_num       = num_tab[sel_idx];
  assign vec_addr      = vec_base + {{(30-NUM_W){1'b0}}, vec_num, 2'b00};
  assign exec_lvl      = top_lvl;
endmodule

// File: rtl/excp_sequencer_chk.sv
module excp_sequencer_chk #(
  parameter int NUM_W      = 5,
  parameter int LVL_W      = 3,
  parameter int THREAD_LVL = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_return,
  input logic             stk_req_valid,
  input logic             stk_req_ready,
  input logic             stk_req_pop,
  input logic             stk_req_psp,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic [NUM_W-1:0] vec_num,
  input logic [LVL_W-1:0] exec_lvl
);
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_num));  // R11
  AST_STK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stk_req_valid && !stk_req_ready |=> stk_req_valid && $stable(stk_req_pop) && $stable(stk_req_psp));  // R11
  AST_NO_VEC_DURING_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && stk_req_valid));  // R6
  AST_LVL_RISES_ONLY_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_return |=> exec_lvl <= $past(exec_lvl));  // R9
  AST_ENTRY_RAISES_URGENCY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> exec_lvl < $past(exec_lvl));  // R5
  AST_THREAD_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return && exec_lvl == LVL_W'(THREAD_LVL) && !(vec_valid && vec_ready)
      |=> exec_lvl == LVL_W'(THREAD_LVL));  // R12
endmodule

bind excp_sequencer excp_sequencer_chk #(
  .NUM_W(NUM_W), .LVL_W(LVL_W), .THREAD_LVL(THREAD_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_return(exc_return),
  .stk_req_valid(stk_req_valid), .stk_req_ready(stk_req_ready),
  .stk_req_pop(stk_req_pop), .stk_req_psp(stk_req_psp),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_num(vec_num),
  .exec_lvl(exec_lvl)
);

// File: tb/excp_sequencer_tb.sv
module excp_sequencer_tb;
  localparam int NUM_IRQ = 4;
  localparam int PRIO_W  = 2;
  localparam int NCFG    = 3 + NUM_IRQ;
  localparam int NSRC    = 3 + NCFG;
  localparam int BURST   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0]             vec_base = 32'h0;
  logic                    thread_psp = 1'b0;
  logic [NSRC-1:0]         req_v = '0;
  logic [NCFG*PRIO_W-1:0]  cfg_prio = '0;
  logic [NCFG-1:0]         cfg_en = '1;
  logic                    exc_return = 1'b0;
  logic                    stk_req_valid, stk_req_pop, stk_req_psp;
  logic                    stk_req_ready = 1'b0;
  logic                    stk_done = 1'b0;
  logic                    vec_valid;
  logic                    vec_ready = 1'b0;
  logic [4:0]              vec_num;
  logic [31:0]             vec_addr;
  logic [2:0]              exec_lvl;

  excp_sequencer #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .NEST_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .vec_base(vec_base), .thread_psp(thread_psp),
    .rst_exc_req(req_v[0]), .nmi_req(req_v[1]), .hardfault_req(req_v[2]),
    .svc_req(req_v[3]), .pendsv_req(req_v[4]), .systick_req(req_v[5]),
    .irq_req(req_v[NSRC-1:6]), .cfg_prio(cfg_prio), .cfg_en(cfg_en),
    .exc_return(exc_return), .stk_req_valid(stk_req_valid),
    .stk_req_ready(stk_req_ready), .stk_req_pop(stk_req_pop),
    .stk_req_psp(stk_req_psp), .stk_done(stk_done), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_num(vec_num), .vec_addr(vec_addr),
    .exec_lvl(exec_lvl)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int push_cnt = 0;
  int pop_cnt  = 0;
  bit last_psp = 1'b0;

  // Stacking engine model: ready one cycle after valid, done BURST cycles later
  bit eng_busy = 1'b0;
  int eng_cnt  = 0;
  bit v_prev = 1'b0, op_prev = 1'b0, psp_prev = 1'b0;
  always @(negedge clk) begin
    stk_done = 1'b0;
    if (stk_req_ready) begin
      if (v_prev) begin
        eng_busy = 1'b1;
        eng_cnt  = 0;
        last_psp = psp_prev;
        if (op_prev) pop_cnt++; else push_cnt++;
      end
      stk_req_ready = 1'b0;
    end else if (eng_busy) begin
      eng_cnt++;
      if (eng_cnt == BURST) begin
        stk_done = 1'b1;
        eng_busy = 1'b0;
      end
    end else if (stk_req_valid) begin
      stk_req_ready = 1'b1;
    end
    v_prev   = stk_req_valid;
    op_prev  = stk_req_pop;
    psp_prev = stk_req_psp;
  end

  function automatic int exp_num(input int i);
    case (i)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 11;
      4: return 14;
      5: return 15;
      default: return 16 + i - 6;
    endcase
  endfunction

  function automatic int exp_lvl(input int i);
    if (i < 3) return i;
    return 3 + int'(cfg_prio[(i-3)*PRIO_W +: PRIO_W]);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input int s);
    req_v[s] = 1'b1;
    tick();
    req_v = '0;
  endtask

  task automatic do_return();
    exc_return = 1'b1;
    tick();
    exc_return = 1'b0;
  endtask

  // Wait for a vector offer, check it, stall one cycle, then accept
  task automatic expect_vec(input int num, input string req);
    int w = 0;
    while (!vec_valid && w < 200) begin tick(); w++; end
    check(req, "vector offered", int'(vec_valid), 1);
    check(req, "vector number", int'(vec_num), num);
    check("R4", "vector address", int'(vec_addr), int'(vec_base) + 4 * num);
    tick();
    check("R11", "vector held under stall", int'(vec_valid && vec_num == 5'(num)), 1);
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
  endtask

  task automatic set_prio(input int slot, input int p);
    cfg_prio[slot*PRIO_W +: PRIO_W] = PRIO_W'(p);
  endtask

  // Two sources raised together: winner entered, loser tail-chained, then pop
  task automatic run_pair(input int i, input int j);
    int p0 = push_cnt, q0 = pop_cnt, w, l;
    w = (exp_lvl(j) < exp_lvl(i)) ? j : i;
    l = (w == i) ? j : i;
    req_v[i] = 1'b1;
    req_v[j] = 1'b1;
    tick();
    req_v = '0;
    expect_vec(exp_num(w), "R2");
    check("R6", "one push on entry", push_cnt, p0 + 1);
    check("R6", "push stack select from thread", int'(last_psp), int'(thread_psp));
    check("R5", "level after entry", int'(exec_lvl), exp_lvl(w));
    do_return();
    expect_vec(exp_num(l), "R8");
    check("R8", "no pop on tail chain", pop_cnt, q0);
    check("R8", "no push on tail chain", push_cnt, p0 + 1);
    do_return();
    tick(20);
    check("R9", "one pop on final return", pop_cnt, q0 + 1);
    check("R9", "pop stack select", int'(last_psp), int'(thread_psp));
    check("R9", "thread level restored", int'(exec_lvl), 7);
    check("R13", "nothing left pending", int'(vec_valid || stk_req_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int p0, q0;
    tick(3);
    check("R1", "vec_valid after reset", int'(vec_valid), 0);
    check("R1", "stk_req_valid after reset", int'(stk_req_valid), 0);
    check("R1", "exec_lvl after reset", int'(exec_lvl), 7);
    rst_n = 1'b1;
    tick(2);
    check("R1", "idle after reset release", int'(vec_valid || stk_req_valid), 0);
    check("R1", "thread level after release", int'(exec_lvl), 7);

    // Sweep every source pair under four priority maps
    for (int c = 0; c < 4; c++) begin
      vec_base   = 32'h1000 * (c + 1);
      thread_psp = c[0];
      cfg_en     = '1;
      for (int i = 0; i < NSRC; i++) begin
        for (int j = i + 1; j < NSRC; j++) begin
          for (int k = 0; k < NCFG; k++) set_prio(k, (k * c + c + k / 2) % 4);
          run_pair(i, j);
        end
      end
    end

    // R12: return at thread level is ignored
    q0 = pop_cnt;
    do_return();
    tick(15);
    check("R12", "no pop at thread", pop_cnt, q0);
    check("R12", "level stays thread", int'(exec_lvl), 7);

    // R3: disabled source waits, fixed source ignores enables
    vec_base = 32'h0000_2000;
    cfg_en = '0;
    p0 = push_cnt;
    q0 = pop_cnt;
    req_v[8] = 1'b1;  // IRQ 2
    req_v[2] = 1'b1;  // hard fault
    tick();
    req_v = '0;
    expect_vec(3, "R3");
    do_return();
    tick(20);
    check("R3", "disabled source not tail-chained", pop_cnt, q0 + 1);
    check("R3", "disabled source not taken", int'(vec_valid || stk_req_valid), 0);
    cfg_en[5] = 1'b1;
    expect_vec(18, "R3");
    check("R3", "enabled source entered with push", push_cnt, p0 + 2);
    do_return();
    tick(20);
    cfg_en = '1;

    // R7: late arrival during push burst
    set_prio(3, 3);
    set_prio(4, 0);
    p0 = push_cnt;
    q0 = pop_cnt;
    pulse(6);
    for (int w = 0; w < 50 && push_cnt == p0; w++) tick();
    pulse(7);
    expect_vec(17, "R7");
    check("R7", "no second push", push_cnt, p0 + 1);
    do_return();
    expect_vec(16, "R7");
    check("R8", "displaced source tail-chained without pop", pop_cnt, q0);
    do_return();
    tick(20);
    check("R9", "pop after late-arrival chain", pop_cnt, q0 + 1);

    // R5 / R10: nesting to full depth
    thread_psp = 1'b1;
    set_prio(0, 3); set_prio(1, 2); set_prio(2, 1); set_prio(3, 0);
    set_prio(4, 3); set_prio(5, 3); set_prio(6, 3);
    pulse(3);
    expect_vec(11, "R5");
    check("R6", "thread entry uses process stack", int'(last_psp), 1);
    check("R5", "level 6", int'(exec_lvl), 6);
    p0 = push_cnt;
    pulse(7);
    tick(20);
    check("R5", "equal level does not preempt", int'(vec_valid), 0);
    check("R5", "no push for equal level", push_cnt, p0);
    pulse(4);
    expect_vec(14, "R5");
    check("R6", "nested entry uses main stack", int'(last_psp), 0);
    pulse(5);
    expect_vec(15, "R5");
    pulse(6);
    expect_vec(16, "R5");
    check("R10", "level 3 at depth 4", int'(exec_lvl), 3);
    p0 = push_cnt;
    q0 = pop_cnt;
    pulse(1);
    tick(20);
    check("R10", "no preemption when full", int'(vec_valid), 0);
    check("R10", "no push when full", push_cnt, p0);
    do_return();
    expect_vec(2, "R10");
    check("R8", "non-maskable tail-chained", pop_cnt, q0);
    check("R5", "level 1", int'(exec_lvl), 1);
    do_return();
    tick(20);
    check("R9", "pop back to level 4", pop_cnt, q0 + 1);
    check("R9", "level 4 restored", int'(exec_lvl), 4);
    do_return();
    tick(20);
    check("R9", "level 5 restored", int'(exec_lvl), 5);
    do_return();
    tick(20);
    check("R9", "level 6 restored", int'(exec_lvl), 6);
    q0 = pop_cnt;
    do_return();
    expect_vec(17, "R8");
    check("R8", "no pop before waiting source", pop_cnt, q0);
    do_return();
    tick(20);
    check("R9", "pop to thread", pop_cnt, q0 + 1);
    check("R9", "thread pop uses saved process stack", int'(last_psp), 1);
    check("R9", "thread level at end", int'(exec_lvl), 7);
    check("R13", "idle at end", int'(vec_valid || stk_req_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule